// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between a parallel flash bus and the embedded controller that carries out program and erase operations. It watches chip enable, write enable, output enable, a 17-bit address and an 8-bit write data bus. Write-enable edges are sampled with the system clock. Multi-cycle unlock sequences are matched one write at a time. Each completed command becomes a one-cycle request to the controller. The request carries the target address and, for programming, the data byte.

The block also decides what a bus read returns. Normally that is the array data supplied from outside. In identifier mode it returns the manufacturer code, the device code or the protect status of the addressed sector. The controller reports three things: a program in progress, a sector erase active, and an erase suspended. The decoder uses these to discard or restrict commands.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset no request is issued and a read returns the array data input, registered one clock later.
- R2: The writes AAh at 555h, 55h at 2AAh and A0h at 555h, followed by any fourth write, give one program request. That request carries the full 17-bit address and data of the fourth write.
- R3: Unlock and command addresses compare only address bits 10:0, so bits 16:11 of those writes may take any value.
- R4: Two unlock pairs around 80h at 555h, followed by 10h at 555h, give one chip erase request.
- R5: The same six-write prefix ending in 30h at any address gives one sector erase request carrying that full address.
- R6: A write with a wrong address or data aborts the sequence without a request and returns to array read. A correct sequence afterwards still completes.
- R7: A single F0h write at any address, outside the program data cycle, gives a reset request and leaves identifier mode.
- R8: After AAh/555h, 55h/2AAh, 90h/555h, reads decode address bits 1:0. Code 0 returns C2h, code 1 returns the device code (default 18h), code 2 returns 01h for a protected sector and 00h otherwise, and code 3 returns 00h.
- R9: While the program busy input is high, writes are discarded with no request and no change to the sequence in progress.
- R10: While a sector erase is active and not suspended, B0h at any address gives a suspend request. Every other write, F0h included, gives no request.
- R11: 30h at any address from read mode gives a resume request only while the erase is suspended. Otherwise it gives no request.
- R12: A write counts only when chip enable is low and output enable is high at the rising edge of write enable.
- R13: Each completed command gives exactly one request output, one clock wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_ce_n | input | 1 | Chip enable, active low |
| bus_we_n | input | 1 | Write enable, active low |
| bus_oe_n | input | 1 | Output enable, active low |
| bus_addr | input | 17 | Bus address |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Read data returned to the bus |
| arr_rdata | input | 8 | Array data at the current address |
| sec_protected | input | 1 | Protect status of the addressed sector |
| ctl_prog_busy | input | 1 | Controller is programming a byte |
| ctl_erase_active | input | 1 | A sector erase is running or suspended |
| ctl_erase_susp | input | 1 | The running sector erase is suspended |
| req_prog | output | 1 | Program request pulse |
| req_chip_erase | output | 1 | Chip erase request pulse |
| req_sector_erase | output | 1 | Sector erase request pulse |
| req_suspend | output | 1 | Erase suspend request pulse |
| req_resume | output | 1 | Erase resume request pulse |
| req_reset | output | 1 | Reset-to-read request pulse |
| req_addr | output | 17 | Address that goes with the request |
| req_data | output | 8 | Data that goes with the request |
| id_mode | output | 1 | High while reads return identifier data |

## Verification
Some properties are checked by assertions on every cycle. The internal write strobe is never longer than one clock. A write during programming never gives a request. A write during a running erase gives at most a suspend. Request pulses never stretch. Outside identifier mode the read output tracks the array input. Only the directed scenarios can show that a full sequence is matched. They also show that the upper address bits are ignored for unlock writes but kept for program and sector targets. The remaining scenario-only behaviours are aborts, the identifier decode, the chip-enable and output-enable qualification, and that a discarded write leaves a partial sequence intact.

// File: rtl/flash_cmd_pkg.sv
// Package: shared constants and types for the flash command decoder.
// Assumes an 8-bit data bus and unlock addresses compared on 11 bits.
package flash_cmd_pkg;
    localparam int DATA_W = 8;
    localparam int CMP_W  = 11;

    localparam logic [CMP_W-1:0] UNLOCK_ADDR_A = 11'h555;
    localparam logic [CMP_W-1:0] UNLOCK_ADDR_B = 11'h2AA;

    localparam logic [DATA_W-1:0] KEY_A      = 8'hAA;
    localparam logic [DATA_W-1:0] KEY_B      = 8'h55;
    localparam logic [DATA_W-1:0] OP_IDENT   = 8'h90;
    localparam logic [DATA_W-1:0] OP_PROGRAM = 8'hA0;
    localparam logic [DATA_W-1:0] OP_ERASE   = 8'h80;
    localparam logic [DATA_W-1:0] OP_CHIP    = 8'h10;
    localparam logic [DATA_W-1:0] OP_SECTOR  = 8'h30;
    localparam logic [DATA_W-1:0] OP_RESUME  = 8'h30;
    localparam logic [DATA_W-1:0] OP_SUSPEND = 8'hB0;
    localparam logic [DATA_W-1:0] OP_RESET   = 8'hF0;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_KEY1,
        SQ_KEY2,
        SQ_IDENT,
        SQ_PROG,
        SQ_ERS1,
        SQ_ERS2,
        SQ_ERS3
    } seq_state_t;

    typedef enum logic [2:0] {
        RQ_NONE,
        RQ_PROG,
        RQ_CHIP,
        RQ_SECT,
        RQ_SUSP,
        RQ_RESUME,
        RQ_RESET
    } req_kind_t;
endpackage

// File: rtl/flash_we_sync.sv
// Module: flash_we_sync
// Brings the asynchronous write enable into the clock domain through two
// flops, detects its edges, latches the address on the falling edge and the
// data on the rising edge, and emits a one-cycle write strobe.
// Assumes address and data are stable for several clocks around each edge,
// and that chip and output enable are steady around the rising edge.
module flash_we_sync
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    logic we_s1, we_s2, we_s3;
    logic we_fall, we_rise;
    logic [ADDR_W-1:0] addr_hold;

    // Synchroniser chain plus one delay stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_s1 <= 1'b1;
            we_s2 <= 1'b1;
            we_s3 <= 1'b1;
        end else begin
            we_s1 <= we_n;
            we_s2 <= we_s1;
            we_s3 <= we_s2;
        end
    end

    // Edge decode of the synchronised write enable.
    always_comb begin
        we_fall = we_s3 & ~we_s2;
        we_rise = ~we_s3 & we_s2;
    end

    // Address capture at the falling edge of write enable.
    always_ff @(posedge clk) begin
        if (!rst_n) addr_hold <= '0;
        else if (we_fall) addr_hold <= addr;
    end

    // Strobe with data captured at the rising edge, qualified by the enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_stb  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_stb <= we_rise & ~ce_n & oe_n;
            if (we_rise) begin
                wr_addr <= addr_hold;
                wr_data <= wdata;
            end
        end
    end

    assert_strobe_one_cycle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);
endmodule

// File: rtl/flash_seq_fsm.sv
// Module: flash_seq_fsm
// Matches unlock/command write sequences one strobe at a time and issues
// one-cycle requests. Gates commands by the controller's operation state.
// Assumes at most one write strobe per clock and strobes at least two
// clocks apart.
module flash_seq_fsm
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              prog_busy,
    input  logic              erase_active,
    input  logic              erase_susp,
    output logic              req_prog,
    output logic              req_chip_erase,
    output logic              req_sector_erase,
    output logic              req_suspend,
    output logic              req_resume,
    output logic              req_reset,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_data,
    output logic              id_mode
);
    seq_state_t state, nxt_state;
    req_kind_t  kind;
    logic       at_a, at_b;

    // Low-address comparison against the two unlock addresses.
    always_comb begin
        at_a = (wr_addr[CMP_W-1:0] == UNLOCK_ADDR_A);
        at_b = (wr_addr[CMP_W-1:0] == UNLOCK_ADDR_B);
    end

    // Next-state and request decode for one incoming write.
    always_comb begin
        nxt_state = state;
        kind      = RQ_NONE;
        if (wr_stb) begin
            if (prog_busy) begin
                nxt_state = state;
            end else if (erase_active && !erase_susp) begin
                if (wr_data == OP_SUSPEND) begin
                    kind      = RQ_SUSP;
                    nxt_state = SQ_IDLE;
                end
            end else if (state == SQ_PROG) begin
                kind      = RQ_PROG;
                nxt_state = SQ_IDLE;
            end else if (wr_data == OP_RESET) begin
                kind      = RQ_RESET;
                nxt_state = SQ_IDLE;
            end else if (erase_susp && wr_data == OP_RESUME &&
                         (state == SQ_IDLE || state == SQ_IDENT)) begin
                kind      = RQ_RESUME;
                nxt_state = SQ_IDLE;
            end else begin
                nxt_state = SQ_IDLE;
                unique case (state)
                    SQ_IDLE, SQ_IDENT: begin
                        if (at_a && wr_data == KEY_A) nxt_state = SQ_KEY1;
                    end
                    SQ_KEY1: begin
                        if (at_b && wr_data == KEY_B) nxt_state = SQ_KEY2;
                    end
                    SQ_KEY2: begin
                        if (at_a) begin
                            if (wr_data == OP_IDENT)   nxt_state = SQ_IDENT;
                            if (wr_data == OP_PROGRAM) nxt_state = SQ_PROG;
                            if (wr_data == OP_ERASE)   nxt_state = SQ_ERS1;
                        end
                    end
                    SQ_ERS1: begin
                        if (at_a && wr_data == KEY_A) nxt_state = SQ_ERS2;
                    end
                    SQ_ERS2: begin
                        if (at_b && wr_data == KEY_B) nxt_state = SQ_ERS3;
                    end
                    SQ_ERS3: begin
                        if (at_a && wr_data == OP_CHIP) kind = RQ_CHIP;
                        else if (wr_data == OP_SECTOR)  kind = RQ_SECT;
                    end
                    default: nxt_state = SQ_IDLE;
                endcase
            end
        end
    end

    // Sequence state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SQ_IDLE;
        else        state <= nxt_state;
    end

    // Registered one-cycle request outputs with their address and data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_prog         <= 1'b0;
            req_chip_erase   <= 1'b0;
            req_sector_erase <= 1'b0;
            req_suspend      <= 1'b0;
            req_resume       <= 1'b0;
            req_reset        <= 1'b0;
            req_addr         <= '0;
            req_data         <= '0;
        end else begin
            req_prog         <= (kind == RQ_PROG);
            req_chip_erase   <= (kind == RQ_CHIP);
            req_sector_erase <= (kind == RQ_SECT);
            req_suspend      <= (kind == RQ_SUSP);
            req_resume       <= (kind == RQ_RESUME);
            req_reset        <= (kind == RQ_RESET);
            if (kind != RQ_NONE) begin
                req_addr <= wr_addr;
                req_data <= wr_data;
            end
        end
    end

    // Identifier read mode follows the sequence state.
    always_comb id_mode = (state == SQ_IDENT);

    assert_prog_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && prog_busy) |=> !(req_prog || req_chip_erase || req_sector_erase ||
                                    req_suspend || req_resume || req_reset));
    assert_erase_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !prog_busy && erase_active && !erase_susp) |=>
            !(req_prog || req_chip_erase || req_sector_erase || req_resume || req_reset));
    assert_prog_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
        req_prog |=> !req_prog);
    assert_erase_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (req_chip_erase || req_sector_erase) |=> !(req_chip_erase || req_sector_erase));
endmodule

// File: rtl/flash_read_mux.sv
// Module: flash_read_mux
// Registers the bus read data: array data normally, identifier codes or the
// sector protect flag while identifier mode is active.
// Assumes the address is stable for at least two clocks before sampling.
module flash_read_mux
    import flash_cmd_pkg::*;
#(
    parameter logic [DATA_W-1:0] MFR_CODE = 8'hC2,
    parameter logic [DATA_W-1:0] DEV_CODE = 8'h18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              id_mode,
    input  logic [1:0]        sel,
    input  logic [DATA_W-1:0] arr_rdata,
    input  logic              sec_protected,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] id_val;

    // Identifier decode from the low two address bits.
    always_comb begin
        unique case (sel)
            2'd0:    id_val = MFR_CODE;
            2'd1:    id_val = DEV_CODE;
            2'd2:    id_val = {{(DATA_W-1){1'b0}}, sec_protected};
            default: id_val = '0;
        endcase
    end

    // Output register selecting identifier or array data.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= id_mode ? id_val : arr_rdata;
    end

    assert_array_path_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!id_mode && $past(rst_n)) |=> (rdata == $past(arr_rdata)));
endmodule

// File: rtl/flash_cmd_decoder.sv
// Module: flash_cmd_decoder (top)
// Decodes flash bus write sequences into controller requests and selects
// the bus read data. Assumes the controller's status inputs are synchronous
// to clk and that the bus holds address/data stable around write edges.
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int                ADDR_W   = 17,
    parameter logic [DATA_W-1:0] MFR_CODE = 8'hC2,
    parameter logic [DATA_W-1:0] DEV_CODE = 8'h18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_ce_n,
    input  logic              bus_we_n,
    input  logic              bus_oe_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] arr_rdata,
    input  logic              sec_protected,
    input  logic              ctl_prog_busy,
    input  logic              ctl_erase_active,
    input  logic              ctl_erase_susp,
    output logic              req_prog,
    output logic              req_chip_erase,
    output logic              req_sector_erase,
    output logic              req_suspend,
    output logic              req_resume,
    output logic              req_reset,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_data,
    output logic              id_mode
);
    logic              wr_stb;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;

    flash_we_sync #(.ADDR_W(ADDR_W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_n    (bus_we_n),
        .ce_n    (bus_ce_n),
        .oe_n    (bus_oe_n),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .wr_stb  (wr_stb),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    flash_seq_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk              (clk),
        .rst_n            (rst_n),
        .wr_stb           (wr_stb),
        .wr_addr          (wr_addr),
        .wr_data          (wr_data),
        .prog_busy        (ctl_prog_busy),
        .erase_active     (ctl_erase_active),
        .erase_susp       (ctl_erase_susp),
        .req_prog         (req_prog),
        .req_chip_erase   (req_chip_erase),
        .req_sector_erase (req_sector_erase),
        .req_suspend      (req_suspend),
        .req_resume       (req_resume),
        .req_reset        (req_reset),
        .req_addr         (req_addr),
        .req_data         (req_data),
        .id_mode          (id_mode)
    );

    flash_read_mux #(.MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_rmux (
        .clk           (clk),
        .rst_n         (rst_n),
        .id_mode       (id_mode),
        .sel           (bus_addr[1:0]),
        .arr_rdata     (arr_rdata),
        .sec_protected (sec_protected),
        .rdata         (bus_rdata)
    );
endmodule

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [16:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [7:0]  arr = 8'h5A;
    logic        prot = 1'b0;
    logic        pbusy = 1'b0, eact = 1'b0, esusp = 1'b0;
    logic        r_prog, r_chip, r_sect, r_susp, r_res, r_rst;
    logic [16:0] r_addr;
    logic [7:0]  r_data;
    logic        idm;

    int total = 0, bad = 0;
    int n_prog = 0, n_chip = 0, n_sect = 0, n_susp = 0, n_res = 0, n_rst = 0;
    logic [16:0] last_addr = '0;
    logic [7:0]  last_data = '0;

    always #2.5 clk = ~clk;

    flash_cmd_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .bus_ce_n(ce_n), .bus_we_n(we_n), .bus_oe_n(oe_n),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .arr_rdata(arr),
        .sec_protected(prot), .ctl_prog_busy(pbusy), .ctl_erase_active(eact),
        .ctl_erase_susp(esusp), .req_prog(r_prog), .req_chip_erase(r_chip),
        .req_sector_erase(r_sect), .req_suspend(r_susp), .req_resume(r_res),
        .req_reset(r_rst), .req_addr(r_addr), .req_data(r_data), .id_mode(idm)
    );

    // Request monitor: counts pulses and keeps the payload of the last one.
    always @(posedge clk) begin
        if (r_prog) n_prog++;
        if (r_chip) n_chip++;
        if (r_sect) n_sect++;
        if (r_susp) n_susp++;
        if (r_res)  n_res++;
        if (r_rst)  n_rst++;
        if (r_prog | r_chip | r_sect | r_susp | r_res | r_rst) begin
            last_addr = r_addr;
            last_data = r_data;
        end
    end

    function automatic int n_all();
        return n_prog + n_chip + n_sect + n_susp + n_res + n_rst;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bus_wr(input logic [16:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = 1'b1;
        wait_clk(2);
        we_n = 1'b0;
        wait_clk(4);
        wdata = d;
        wait_clk(1);
        we_n = 1'b1;
        wait_clk(4);
        ce_n = 1'b1;
        wait_clk(2);
    endtask

    task automatic bus_rd(input logic [16:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = 1'b0;
        wait_clk(3);
        d = rdata;
        ce_n = 1'b1; oe_n = 1'b1;
        wait_clk(1);
    endtask

    task automatic unlock();
        bus_wr(17'h00555, 8'hAA);
        bus_wr(17'h002AA, 8'h55);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1 no request after reset", n_all(), 0);
        arr = 8'h3C;
        bus_rd(17'h00010, d);
        chk("R1 array read", d, 8'h3C);
    endtask

    task automatic t_program();
        int p0 = n_prog;
        unlock();
        bus_wr(17'h00555, 8'hA0);
        bus_wr(17'h1ABCD, 8'h96);
        chk("R2 one program request", n_prog - p0, 1);
        chk("R2 program address", last_addr, 17'h1ABCD);
        chk("R2 program data", last_data, 8'h96);
    endtask

    task automatic t_addr_mask();
        int p0 = n_prog;
        bus_wr(17'h1D555, 8'hAA);
        bus_wr(17'h0A2AA, 8'h55);
        bus_wr(17'h1F555, 8'hA0);
        bus_wr(17'h00042, 8'h11);
        chk("R3 upper bits ignored on unlock", n_prog - p0, 1);
        chk("R3 target keeps full address", last_addr, 17'h00042);
    endtask

    task automatic t_chip_erase();
        int c0 = n_chip, a0 = n_all();
        unlock();
        bus_wr(17'h00555, 8'h80);
        unlock();
        bus_wr(17'h00555, 8'h10);
        chk("R4 chip erase request", n_chip - c0, 1);
        chk("R13 single request for chip erase", n_all() - a0, 1);
    endtask

    task automatic t_sector_erase();
        int s0 = n_sect;
        unlock();
        bus_wr(17'h00555, 8'h80);
        unlock();
        bus_wr(17'h1C000, 8'h30);
        chk("R5 sector erase request", n_sect - s0, 1);
        chk("R5 sector address", last_addr, 17'h1C000);
    endtask

    task automatic t_abort();
        logic [7:0] d;
        int a0 = n_all();
        int p0 = n_prog;
        bus_wr(17'h00555, 8'hAA);
        bus_wr(17'h00555, 8'h55);
        bus_wr(17'h00555, 8'hA0);
        bus_wr(17'h00300, 8'h77);
        chk("R6 bad unlock address gives no request", n_all() - a0, 0);
        unlock();
        bus_wr(17'h00555, 8'h90);
        unlock();
        bus_wr(17'h00555, 8'h12);
        chk("R6 bad command leaves identifier mode", idm, 0);
        arr = 8'hE1;
        bus_rd(17'h00000, d);
        chk("R6 back to array read", d, 8'hE1);
        unlock();
        bus_wr(17'h00555, 8'hA0);
        bus_wr(17'h00123, 8'h44);
        chk("R6 next sequence still works", n_prog - p0, 1);
    endtask

    task automatic t_ident();
        logic [7:0] d;
        unlock();
        bus_wr(17'h00555, 8'h90);
        chk("R8 identifier mode entered", idm, 1);
        bus_rd(17'h00000, d);
        chk("R8 manufacturer code", d, 8'hC2);
        bus_rd(17'h00001, d);
        chk("R8 device code", d, 8'h18);
        prot = 1'b1;
        bus_rd(17'h0E002, d);
        chk("R8 protected sector", d, 8'h01);
        prot = 1'b0;
        bus_rd(17'h0E002, d);
        chk("R8 unprotected sector", d, 8'h00);
        bus_rd(17'h00003, d);
        chk("R8 code 3 reads zero", d, 8'h00);
    endtask

    task automatic t_reset_cmd();
        logic [7:0] d;
        int r0 = n_rst;
        bus_wr(17'h13579, 8'hF0);
        chk("R7 reset request", n_rst - r0, 1);
        chk("R7 identifier mode left", idm, 0);
        arr = 8'h81;
        bus_rd(17'h00001, d);
        chk("R7 array read after reset", d, 8'h81);
    endtask

    task automatic t_prog_busy();
        int a0 = n_all();
        int p0;
        unlock();
        pbusy = 1'b1;
        bus_wr(17'h00555, 8'hF0);
        bus_wr(17'h00000, 8'h00);
        pbusy = 1'b0;
        chk("R9 no request while programming", n_all() - a0, 0);
        p0 = n_prog;
        bus_wr(17'h00555, 8'hA0);
        bus_wr(17'h00777, 8'h5E);
        chk("R9 sequence state kept across busy writes", n_prog - p0, 1);
        chk("R9 program data after busy", last_data, 8'h5E);
    endtask

    task automatic t_erase_gate();
        int a0, s0;
        eact = 1'b1;
        a0 = n_all();
        bus_wr(17'h00000, 8'hF0);
        unlock();
        bus_wr(17'h00555, 8'hA0);
        bus_wr(17'h00001, 8'h01);
        chk("R10 other commands ignored during erase", n_all() - a0, 0);
        s0 = n_susp;
        bus_wr(17'h10101, 8'hB0);
        chk("R10 suspend accepted", n_susp - s0, 1);
        chk("R13 suspend is the only request", n_all() - a0, 1);
    endtask

    task automatic t_resume();
        int r0, a0;
        esusp = 1'b1;
        r0 = n_res;
        bus_wr(17'h04444, 8'h30);
        chk("R11 resume while suspended", n_res - r0, 1);
        esusp = 1'b0;
        eact = 1'b0;
        a0 = n_all();
        bus_wr(17'h04444, 8'h30);
        bus_wr(17'h04444, 8'hB0);
        chk("R11 resume and suspend ignored with no erase", n_all() - a0, 0);
    endtask

    task automatic t_bus_qualify();
        int a0 = n_all();
        @(negedge clk);
        addr = 17'h00000; ce_n = 1'b1; oe_n = 1'b1;
        wait_clk(2); we_n = 1'b0; wait_clk(4); wdata = 8'hF0; wait_clk(1);
        we_n = 1'b1; wait_clk(6);
        chk("R12 write ignored with chip enable high", n_all() - a0, 0);
        ce_n = 1'b0; oe_n = 1'b0;
        wait_clk(2); we_n = 1'b0; wait_clk(4); wait_clk(1);
        we_n = 1'b1; wait_clk(6);
        ce_n = 1'b1; oe_n = 1'b1;
        chk("R12 write ignored with output enable low", n_all() - a0, 0);
        bus_wr(17'h00000, 8'hF0);
        chk("R12 qualified write accepted", n_all() - a0, 1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(2);
        t_reset();
        t_program();
        t_addr_mask();
        t_chip_erase();
        t_sector_erase();
        t_abort();
        t_ident();
        t_reset_cmd();
        t_prog_busy();
        t_erase_gate();
        t_resume();
        t_bus_qualify();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule